// File: doc/BRIEF.md
# Lockable Debug Register Window

This block is the 4 KB memory-mapped management page that sits in front of a debug or monitoring component. The bus addresses it by 32-bit word offset (10 bits). A small set of offsets near the top of the page is decoded locally. These offsets hold a key-protected write lock, its status, a set of eight claim bits, an authentication summary, a device class code, a configuration word, and the identification bytes that tools read to discover what sits behind the page.

All other offsets are forwarded to a downstream register port, which holds, for example, the counters of a monitoring unit. Reads of those offsets return the downstream read data unchanged.

After reset the page is locked. In the locked state every write is dropped, whether it targets a local register or the downstream port. The one exception is a write to the lock access register. Writing the unlock key there opens the page, and writing any other value closes it again. Reads work in both states.

Top module: `dbg_lock_window`

## Requirements
- R1: After reset the page is locked, all claim bits are 0 and the export flag (configuration bit 16) is 0.
- R2: A write to word offset 0x3EC (lock access) clears the lock when the data is 0xC5ACCE55 and sets it for any other data. This write is accepted whatever the lock state.
- R3: While locked, a write to any offset other than 0x3EC changes no local register and does not assert `dn_wr`.
- R4: Word offset 0x3ED (lock status) reads 0x1 when unlocked and 0x3 when locked. Bit 0 is "lock implemented", bit 1 is the lock state, and bit 2 is 0.
- R5: Word offset 0x3E8 (claim set) always reads 0xFF. When unlocked, writing to it ORs data bits 7:0 into the claim bits.
- R6: Word offset 0x3E9 (claim clear) reads the claim bits in bits 7:0. When unlocked, each data bit 7:0 written as 1 clears the matching claim bit.
- R7: Word offset 0x3F3 (device type) reads 0x16: class 0x6 in bits 3:0 and subtype 0x1 in bits 7:4.
- R8: Word offsets 0x3F4 to 0x3FB each read one byte of the 64-bit `PERIPH_ID` in bits 7:0. Offset 0x3F4+k returns byte (k+4) mod 8, so bytes 4..7 come first and bytes 0..3 follow.
- R9: Word offsets 0x3FC to 0x3FF return bytes 0 to 3 of `COMP_ID` (default 0xB105900D) in bits 7:0.
- R10: Word offset 0x380 (configuration) reads `NUM_CNT` in bits 7:0 and 0x1F in bits 13:8. Bits 14, 15 and 19 read as 1, and bit 16 is the export flag. When unlocked, a write to this offset loads bit 16 from data bit 16.
- R11: Word offset 0x3EE (authentication) reads 0x80 with bit 6 equal to the `sec_observe_en` input.
- R12: Every other offset is downstream. A read asserts `dn_rd` and returns `dn_rdata`. When unlocked, a write asserts `dn_wr` for one cycle with `dn_addr` and `dn_wdata` equal to the bus values. Local offsets never assert `dn_rd` or `dn_wr`.
- R13: All bits not named above read as 0 at local offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 10 | Word offset within the page |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the offset |
| sec_observe_en | input | 1 | Secure non-invasive observation enabled, shown in authentication bit 6 |
| dn_addr | output | 10 | Downstream word offset |
| dn_wr | output | 1 | Downstream write strobe, gated by the lock |
| dn_rd | output | 1 | Downstream read strobe |
| dn_wdata | output | 32 | Downstream write data |
| dn_rdata | input | 32 | Downstream read data |

## Verification
On every cycle the assertions check four things. The lock never lets a write through to the downstream port. The claim bits and the export flag hold still in any cycle that starts locked. Key and non-key writes to the lock register give the next-cycle lock state. The constant registers and the lock status return their fixed patterns when read. The offset sweeps in the bench show the parts that no single-cycle property covers: the identification byte order, the exact set of offsets decoded locally, and the count of forwarded writes across the whole page. The bench also shows the read-modify effects of claim set and clear.

// File: rtl/dbg_lock_window_pkg.sv
package dbg_lock_window_pkg;
  localparam int unsigned WORD_AW = 10;
  localparam int unsigned DW      = 32;

  localparam logic [WORD_AW-1:0] OFS_CONFIG    = 10'h380;
  localparam logic [WORD_AW-1:0] OFS_CLAIM_SET = 10'h3E8;
  localparam logic [WORD_AW-1:0] OFS_CLAIM_CLR = 10'h3E9;
  localparam logic [WORD_AW-1:0] OFS_LOCK_KEY  = 10'h3EC;
  localparam logic [WORD_AW-1:0] OFS_LOCK_STAT = 10'h3ED;
  localparam logic [WORD_AW-1:0] OFS_AUTH      = 10'h3EE;
  localparam logic [WORD_AW-1:0] OFS_DEVTYPE   = 10'h3F3;
  localparam logic [WORD_AW-1:0] OFS_PID_FIRST = 10'h3F4;
  localparam logic [WORD_AW-1:0] OFS_CID_FIRST = 10'h3FC;

  localparam logic [DW-1:0] UNLOCK_KEY = 32'hC5AC_CE55;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CONFIG, SEL_CLAIM_SET, SEL_CLAIM_CLR, SEL_LOCK_KEY,
    SEL_LOCK_STAT, SEL_AUTH, SEL_DEVTYPE, SEL_ID
  } page_sel_e;

  // Identification words occupy the top twelve offsets of the page.
  function automatic logic in_id_range(input logic [WORD_AW-1:0] a);
    return a >= OFS_PID_FIRST;
  endfunction

  // Peripheral ID slot k maps to byte k+4 modulo 8: flipping bit 2.
  function automatic logic [2:0] pid_byte_index(input logic [2:0] slot);
    return slot ^ 3'd4;
  endfunction

  function automatic logic [7:0] pick_byte64(input logic [63:0] v, input logic [2:0] idx);
    return v[idx*8 +: 8];
  endfunction

  function automatic page_sel_e decode_offset(input logic [WORD_AW-1:0] a);
    if (in_id_range(a)) return SEL_ID;
    case (a)
      OFS_CONFIG:    return SEL_CONFIG;
      OFS_CLAIM_SET: return SEL_CLAIM_SET;
      OFS_CLAIM_CLR: return SEL_CLAIM_CLR;
      OFS_LOCK_KEY:  return SEL_LOCK_KEY;
      OFS_LOCK_STAT: return SEL_LOCK_STAT;
      OFS_AUTH:      return SEL_AUTH;
      OFS_DEVTYPE:   return SEL_DEVTYPE;
      default:       return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/dbg_lock_ctrl.sv
module dbg_lock_ctrl
  import dbg_lock_window_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_we,
  input  logic [DW-1:0] key_data,
  output logic          locked
);
  logic lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lock_q <= 1'b1;
    else if (key_we) lock_q <= (key_data != UNLOCK_KEY);
  end

  assign locked = lock_q;
endmodule

// File: rtl/dbg_claim_reg.sv
module dbg_claim_reg #(
  parameter int unsigned BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_we,
  input  logic            clr_we,
  input  logic [BITS-1:0] wmask,
  output logic [BITS-1:0] claim
);
  logic [BITS-1:0] claim_q;

  for (genvar i = 0; i < BITS; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    claim_q[i] <= 1'b0;
      else if (set_we && wmask[i])   claim_q[i] <= 1'b1;
      else if (clr_we && wmask[i])   claim_q[i] <= 1'b0;
    end
  end

  assign claim = claim_q;
endmodule

// File: rtl/dbg_id_rom.sv
module dbg_id_rom
  import dbg_lock_window_pkg::*;
#(
  parameter logic [63:0] PERIPH_ID = 64'h0000_0004_000B_B000,
  parameter logic [31:0] COMP_ID   = 32'hB105_900D
) (
  input  logic [WORD_AW-1:0] addr,
  output logic [7:0]         id_byte
);
  localparam logic [63:0] CID_WIDE = {32'd0, COMP_ID};

  logic [WORD_AW-1:0] slot;
  assign slot = addr - OFS_PID_FIRST;

  always_comb begin
    if (!in_id_range(addr))  id_byte = 8'h00;
    else if (slot[3] == 1'b0) id_byte = pick_byte64(PERIPH_ID, pid_byte_index(slot[2:0]));
    else                      id_byte = pick_byte64(CID_WIDE, {1'b0, slot[1:0]});
  end
endmodule

// File: rtl/dbg_lock_window.sv
module dbg_lock_window
  import dbg_lock_window_pkg::*;
#(
  parameter int unsigned NUM_CNT   = 31,
  parameter int unsigned CLAIM_W   = 8,
  parameter logic [63:0] PERIPH_ID = 64'h0000_0004_000B_B000,
  parameter logic [31:0] COMP_ID   = 32'hB105_900D
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WORD_AW-1:0] bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic               sec_observe_en,
  output logic [WORD_AW-1:0] dn_addr,
  output logic               dn_wr,
  output logic               dn_rd,
  output logic [DW-1:0]      dn_wdata,
  input  logic [DW-1:0]      dn_rdata
);
  localparam logic [7:0] CNT_FIELD  = 8'(NUM_CNT);
  localparam logic [5:0] SIZE_CODE  = 6'b011111;
  localparam int unsigned EXPORT_BIT = 16;

  page_sel_e          sel;
  logic               is_local;
  logic               lock_state;
  logic               wr_open;
  logic               key_we, claim_set_we, claim_clr_we, cfg_we;
  logic [CLAIM_W-1:0] claim_q;
  logic               export_q;
  logic [7:0]         id_byte;

  assign sel      = decode_offset(bus_addr);
  assign is_local = (sel != SEL_NONE);

  // Every write except the key write needs the page to be open.
  assign wr_open      = bus_wr && !lock_state;
  assign key_we       = bus_wr && (sel == SEL_LOCK_KEY);
  assign claim_set_we = wr_open && (sel == SEL_CLAIM_SET);
  assign claim_clr_we = wr_open && (sel == SEL_CLAIM_CLR);
  assign cfg_we       = wr_open && (sel == SEL_CONFIG);

  dbg_lock_ctrl u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_we   (key_we),
    .key_data (bus_wdata),
    .locked   (lock_state)
  );

  dbg_claim_reg #(.BITS(CLAIM_W)) u_claim (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (claim_set_we),
    .clr_we (claim_clr_we),
    .wmask  (bus_wdata[CLAIM_W-1:0]),
    .claim  (claim_q)
  );

  dbg_id_rom #(.PERIPH_ID(PERIPH_ID), .COMP_ID(COMP_ID)) u_id (
    .addr    (bus_addr),
    .id_byte (id_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      export_q <= 1'b0;
    else if (cfg_we) export_q <= bus_wdata[EXPORT_BIT];
  end

  assign dn_addr  = bus_addr;
  assign dn_wdata = bus_wdata;
  assign dn_wr    = wr_open && !is_local;
  assign dn_rd    = bus_rd && !is_local;

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      SEL_CONFIG: begin
        bus_rdata[7:0]        = CNT_FIELD;
        bus_rdata[13:8]       = SIZE_CODE;
        bus_rdata[14]         = 1'b1;
        bus_rdata[15]         = 1'b1;
        bus_rdata[EXPORT_BIT] = export_q;
        bus_rdata[19]         = 1'b1;
      end
      SEL_CLAIM_SET: bus_rdata[CLAIM_W-1:0] = '1;
      SEL_CLAIM_CLR: bus_rdata[CLAIM_W-1:0] = claim_q;
      SEL_LOCK_KEY:  bus_rdata = '0;
      SEL_LOCK_STAT: bus_rdata[2:0] = {1'b0, lock_state, 1'b1};
      SEL_AUTH:      bus_rdata[7:0] = {1'b1, sec_observe_en, 6'b0};
      SEL_DEVTYPE:   bus_rdata[7:0] = {4'h1, 4'h6};
      SEL_ID:        bus_rdata[7:0] = id_byte;
      SEL_NONE:      bus_rdata = dn_rdata;
      default:       bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dbg_lock_window_chk.sv
module dbg_lock_window_chk
  import dbg_lock_window_pkg::*;
#(
  parameter int unsigned CLAIM_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [WORD_AW-1:0] bus_addr,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [DW-1:0]      bus_wdata,
  input logic [DW-1:0]      bus_rdata,
  input logic               dn_wr,
  input logic               dn_rd,
  input logic               locked,
  input logic [CLAIM_W-1:0] claim_bits,
  input logic               export_flag
);
  AST_NO_WRITE_WHILE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    dn_wr |-> !locked) else $error("downstream write while locked"); // R3
  AST_CLAIM_FROZEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(claim_bits)) else $error("claim changed while locked"); // R3
  AST_EXPORT_FROZEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(export_flag)) else $error("export changed while locked"); // R3
  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_LOCK_KEY && bus_wdata == UNLOCK_KEY) |=> !locked)
    else $error("key did not unlock"); // R2
  AST_BAD_KEY_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_LOCK_KEY && bus_wdata != UNLOCK_KEY) |=> locked)
    else $error("bad key did not lock"); // R2
  AST_LOCK_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_LOCK_STAT) |-> bus_rdata == (locked ? 32'h3 : 32'h1))
    else $error("lock status pattern"); // R4
  AST_CLAIM_SET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_CLAIM_SET) |-> bus_rdata == 32'hFF)
    else $error("claim set read"); // R5
  AST_DEVTYPE_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_DEVTYPE) |-> bus_rdata == 32'h16)
    else $error("device type read"); // R7
  AST_LOCAL_NO_DN_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr >= OFS_PID_FIRST) |-> !dn_rd)
    else $error("id read forwarded"); // R12
endmodule

bind dbg_lock_window dbg_lock_window_chk #(.CLAIM_W(CLAIM_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .dn_wr       (dn_wr),
  .dn_rd       (dn_rd),
  .locked      (lock_state),
  .claim_bits  (claim_q),
  .export_flag (export_q)
);

// File: tb/dbg_lock_window_test.sv
module dbg_lock_window_test;
  localparam int NCNT = 31;
  localparam logic [63:0] PID = 64'h0000_0004_000B_B000;
  localparam logic [31:0] CID = 32'hB105_900D;
  localparam logic [31:0] KEY = 32'hC5AC_CE55;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [9:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, sec_observe_en = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata, dn_wdata, dn_rdata;
  logic [9:0] dn_addr;
  logic dn_wr, dn_rd;

  int total = 0, bad = 0, dn_wr_seen = 0;
  bit done = 1'b0;

  // model state kept from the requirements
  bit m_lock = 1'b1, m_ex = 1'b0;
  logic [7:0] m_claim = 8'h00;

  always #5 clk = ~clk;
  assign dn_rdata = 32'h5A00_0000 | {22'd0, dn_addr} | 32'h0001_0000;

  dbg_lock_window uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sec_observe_en(sec_observe_en),
    .dn_addr(dn_addr), .dn_wr(dn_wr), .dn_rd(dn_rd), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
  );

  always @(posedge clk) if (dn_wr) dn_wr_seen++;

  function automatic bit local_ofs(int a);
    return a == 'h380 || a == 'h3E8 || a == 'h3E9 || (a >= 'h3EC && a <= 'h3EE) || a >= 'h3F3;
  endfunction

  function automatic logic [31:0] expect_rd(int a);
    if (a == 'h380) return NCNT + (31 << 8) + (1 << 14) + (1 << 15) + (m_ex << 16) + (1 << 19);
    if (a == 'h3E8) return 32'd255;
    if (a == 'h3E9) return {24'd0, m_claim};
    if (a == 'h3EC) return 0;
    if (a == 'h3ED) return 1 + 2 * m_lock;
    if (a == 'h3EE) return 128 + 64 * sec_observe_en;
    if (a == 'h3F3) return 16 + 6;
    if (a >= 'h3F4 && a <= 'h3FB) return (PID >> (8 * ((a - 'h3F4 + 4) % 8))) & 64'hFF;
    if (a >= 'h3FC) return (CID >> (8 * (a - 'h3FC))) & 32'hFF;
    return 32'h5A01_0000 + a;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_check(string req, int a);
    @(negedge clk);
    bus_addr = 10'(a); bus_rd = 1'b1;
    #1;
    check(req, bus_rdata, expect_rd(a));
    check("R12 dn_rd", {31'd0, dn_rd}, {31'd0, !local_ofs(a)});
    bus_rd = 1'b0;
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_addr = 10'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_check("R1 lock after reset", 'h3ED);
    rd_check("R1 claim after reset", 'h3E9);
    rd_check("R1 export after reset", 'h380);

    // R13 R7 R8 R9 R11 R12: full read sweep while locked (reads allowed)
    for (int a = 0; a < 1024; a++) rd_check("R13 locked sweep", a);
    sec_observe_en = 1'b1;
    rd_check("R11 auth bit6", 'h3EE);

    // R3: write ones everywhere except the key register while locked
    for (int a = 0; a < 1024; a++) if (a != 'h3EC) wr(a, 32'hFFFF_FFFF);
    check("R3 no dn_wr while locked", dn_wr_seen, 0);
    rd_check("R3 claim untouched", 'h3E9);
    rd_check("R3 export untouched", 'h380);
    rd_check("R3 still locked", 'h3ED);

    // R2 bad key keeps lock, good key opens
    wr('h3EC, KEY ^ 32'h1);
    rd_check("R2 bad key", 'h3ED);
    wr('h3EC, KEY); m_lock = 0;
    rd_check("R2 key unlocks", 'h3ED);

    // R5 R6 claim set/clear
    wr('h3E8, 32'hFFFF_FFA5); m_claim = 8'hA5;
    rd_check("R5 claim set", 'h3E9);
    rd_check("R5 claim set reads ones", 'h3E8);
    wr('h3E8, 32'h0000_0010); m_claim = 8'hB5;
    rd_check("R5 claim or", 'h3E9);
    wr('h3E9, 32'h0000_0015); m_claim = 8'hA0;
    rd_check("R6 claim clear", 'h3E9);

    // R10 export flag
    wr('h380, 32'h0001_0000); m_ex = 1;
    rd_check("R10 export set", 'h380);
    wr('h380, 32'hFFFE_FFFF); m_ex = 0;
    rd_check("R10 export clear", 'h380);

    // R12 downstream write forwarding
    @(negedge clk);
    bus_addr = 10'h123; bus_wdata = 32'hDEAD_BEEF; bus_wr = 1'b1;
    #1;
    check("R12 dn_wr", {31'd0, dn_wr}, 32'd1);
    check("R12 dn_addr", {22'd0, dn_addr}, 32'h123);
    check("R12 dn_wdata", dn_wdata, 32'hDEAD_BEEF);
    @(negedge clk); bus_wr = 1'b0;
    dn_wr_seen = 0;
    for (int a = 0; a < 1024; a++) if (a != 'h3EC && a != 'h3E8 && a != 'h3E9 && a != 'h380) wr(a, 32'h0);
    begin
      int n = 0;
      for (int a = 0; a < 1024; a++) if (!local_ofs(a)) n++;
      check("R12 forwarded write count", dn_wr_seen, n);
    end

    // R13 sweep unlocked with claim bits set
    sec_observe_en = 1'b0;
    for (int a = 'h380; a < 1024; a++) rd_check("R13 unlocked sweep", a);

    // R2 relock with a non-key value, then R3 again
    wr('h3EC, 32'h0); m_lock = 1;
    rd_check("R2 relock", 'h3ED);
    wr('h3E9, 32'hFF);
    rd_check("R3 clear ignored when locked", 'h3E9);

    // R1 reset relocks and clears
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_lock = 1; m_claim = 0; m_ex = 0;
    rd_check("R1 relock on reset", 'h3ED);
    rd_check("R1 claim cleared on reset", 'h3E9);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule